// File: doc/BRIEF.md
# Field-Configurable AND-OR Logic Array

This block is a two-level configurable logic array of the kind found in small programmable logic devices. It has eight dedicated inputs and ten bidirectional pins. Each pin is modelled as three ports: a pad value coming in, a data value going out and an output enable. The eighteen array inputs are the dedicated inputs followed by the ten pad values. Each of them is offered to every product term in true and in complement form. There are 42 product terms. Thirty-two are logic terms that can be OR-ed into any of the ten outputs. Each output then passes through a polarity stage that either keeps the sum of products or inverts it. The last ten terms each drive the output enable of one pin.

The connection pattern is a single map of 1842 bits. It is shifted in one bit per clock while the load signal is high, into a shadow register. It only replaces the working pattern on a commit strobe, and only once a complete map has arrived. Until a commit happens, the array keeps evaluating the previous pattern. The array path itself is purely combinational. A pin whose enable is low reads back as an input through its pad port. The internal data-out is never fed back into the array.

The loader runs a small state machine:
- ST_IDLE, nothing pending. It moves to ST_SHIFT on the first loaded bit (transition START).
- ST_SHIFT, a map is partly received. It stays there while bits arrive or while load pauses (transition ACCEPT). It moves to ST_FULL on the 1842nd bit (transition COMPLETE).
- ST_FULL, a map is waiting. A commit with load low moves it to ST_IDLE and installs the map (transition APPLY). A new load bit moves it back to ST_SHIFT and restarts the count (transition RESTART).

Top module: `pla_array`

## Requirements
- R1: After reset the working map is all ones, so every term holds both polarities of every input. As a result `dout` and `oe` are all zero for any input values.
- R2: Map bit `t*36 + 2*i` connects the true form of array input `i` to term `t`, and bit `t*36 + 2*i + 1` connects its complement. Array inputs 0..7 are `ded_in[7:0]` and 8..17 are `pad_in[9:0]`. A term is the AND of its connected literals, and an input with neither bit set does not affect the term.
- R3: A term with both the true and the complement bit of any one input set is 0 for every input value.
- R4: Map bit `1512 + o*32 + t` connects logic term `t` (0..31) to the OR gate of output `o`. An OR gate with no connected true term gives 0.
- R5: Map bit `1832 + o` selects the polarity of output `o`. A value of 1 passes the OR result to `dout[o]`, and a value of 0 inverts it.
- R6: Term `32 + k` drives `oe[k]` directly.
- R7: The value on `pad_in` is used as array input, whatever `oe` and `dout` are.
- R8: While `cfg_load` is high, `cfg_bit` is sampled at each rising clock edge. The first bit sampled becomes map bit 0 and the 1842nd becomes bit 1841.
- R9: While a map is being shifted in, and while a complete map is waiting, `dout` and `oe` follow the previous working map.
- R10: A commit with `cfg_load` low, sampled once a complete map has been received, makes that map the working map from the next cycle on. A commit at any other time changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration loader |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Shift enable for the serial map |
| cfg_bit | input | 1 | Serial map data, bit 0 first |
| cfg_commit | input | 1 | Installs a complete shadow map |
| ded_in | input | 8 | Dedicated array inputs |
| pad_in | input | 10 | Values seen on the bidirectional pads |
| dout | output | 10 | Data driven to each pad |
| oe | output | 10 | Output enable for each pad |

## Verification
A fixed hand-built map is tried with a table of input vectors. The table separates a true literal from a complement literal, an AND from an OR, active-high outputs from active-low ones, and a pad feedback input from a dedicated one. It also includes a term that holds both polarities of one input and must never fire. Random maps with sparse literals are then compared against a reference model over random inputs. These maps exercise every OR connection and enable term at once. Directed loading patterns cover the remaining cases: a check of the outputs in the middle of a load, a commit on an incomplete map, and a reset. Together they tell the shadow map apart from the working map.

// File: rtl/pla_pkg.sv
package pla_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } ld_state_t;
endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader #(
    parameter int CFG_BITS = 1842,
    parameter int CNT_W    = $clog2(CFG_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic                  cfg_bit,
    input  logic                  cfg_commit,
    output logic [CFG_BITS-1:0]   cfg_q,
    output pla_pkg::ld_state_t    state_q,
    output logic [CNT_W-1:0]      count_q
);
    import pla_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CFG_BITS - 1);

    ld_state_t           state_d;
    logic [CFG_BITS-1:0] shadow_q;
    logic                apply;

    // Next state; the transitions are named as in the brief.
    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_load) state_d = ST_SHIFT;                // START
            end
            ST_SHIFT: begin
                if (cfg_load && count_q == LAST) state_d = ST_FULL;  // COMPLETE
            end
            ST_FULL: begin
                if (cfg_load) begin
                    state_d = ST_SHIFT;                          // RESTART
                end else if (cfg_commit) begin
                    state_d = ST_IDLE;                           // APPLY
                    apply   = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: bit counter, shadow map, working map.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            shadow_q <= '1;
            cfg_q    <= '1;
        end else begin
            if (cfg_load) begin
                shadow_q <= {cfg_bit, shadow_q[CFG_BITS-1:1]};
                if (state_q == ST_SHIFT) begin
                    count_q <= (count_q == LAST) ? '0 : count_q + 1'b1;
                end else begin
                    count_q <= CNT_W'(1);
                end
            end
            if (apply) cfg_q <= shadow_q;
        end
    end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_ARR  = 18,
    parameter int N_TERM = 42,
    localparam int LIT_W = 2 * N_ARR
) (
    input  logic [N_ARR-1:0]        arr_in,
    input  logic [N_TERM*LIT_W-1:0] lit_map,
    output logic [N_TERM-1:0]       term
);
    logic [LIT_W-1:0] dual;

    generate
        for (genvar i = 0; i < N_ARR; i++) begin : g_dual
            assign dual[2*i]     = arr_in[i];
            assign dual[2*i + 1] = ~arr_in[i];
        end
        // A connected literal must be 1; both forms of one input can never both be 1.
        for (genvar t = 0; t < N_TERM; t++) begin : g_term
            assign term[t] = &(~lit_map[t*LIT_W +: LIT_W] | dual);
        end
    endgenerate
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_LOGIC = 32,
    parameter int N_OUT   = 10
) (
    input  logic [N_LOGIC-1:0]       term_logic,
    input  logic [N_OUT*N_LOGIC-1:0] or_map,
    input  logic [N_OUT-1:0]         pol,
    output logic [N_OUT-1:0]         dout
);
    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_out
            logic sop;
            assign sop     = |(term_logic & or_map[o*N_LOGIC +: N_LOGIC]);
            assign dout[o] = sop ^ ~pol[o];
        end
    endgenerate
endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_DED   = 8,
    parameter int N_PIN   = 10,
    parameter int N_LOGIC = 32,
    localparam int N_ARR    = N_DED + N_PIN,
    localparam int LIT_W    = 2 * N_ARR,
    localparam int N_TERM   = N_LOGIC + N_PIN,
    localparam int AND_BITS = N_TERM * LIT_W,
    localparam int OR_BITS  = N_PIN * N_LOGIC,
    localparam int CFG_BITS = AND_BITS + OR_BITS + N_PIN,
    localparam int CNT_W    = $clog2(CFG_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic             cfg_commit,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_PIN-1:0] pad_in,
    output logic [N_PIN-1:0] dout,
    output logic [N_PIN-1:0] oe
);
    logic [CFG_BITS-1:0] cfg_q;
    pla_pkg::ld_state_t  ld_state;
    logic [CNT_W-1:0]    ld_count;
    logic [N_TERM-1:0]   term;

    pla_cfg_loader #(.CFG_BITS(CFG_BITS), .CNT_W(CNT_W)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_bit   (cfg_bit),
        .cfg_commit(cfg_commit),
        .cfg_q     (cfg_q),
        .state_q   (ld_state),
        .count_q   (ld_count)
    );

    // Pad values, not dout, feed the array.
    pla_and_plane #(.N_ARR(N_ARR), .N_TERM(N_TERM)) u_and (
        .arr_in (({pad_in, ded_in})),
        .lit_map(cfg_q[AND_BITS-1:0]),
        .term   (term)
    );

    pla_or_plane #(.N_LOGIC(N_LOGIC), .N_OUT(N_PIN)) u_or (
        .term_logic(term[N_LOGIC-1:0]),
        .or_map    (cfg_q[AND_BITS +: OR_BITS]),
        .pol       (cfg_q[AND_BITS + OR_BITS +: N_PIN]),
        .dout      (dout)
    );

    assign oe = term[N_TERM-1:N_LOGIC];
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
    parameter int CFG_BITS = 1842,
    parameter int N_PIN    = 10,
    parameter int CNT_W    = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_load,
    input logic                cfg_commit,
    input pla_pkg::ld_state_t  ld_state,
    input logic [CNT_W-1:0]    ld_count,
    input logic [CFG_BITS-1:0] cfg_q,
    input logic [N_PIN-1:0]    dout,
    input logic [N_PIN-1:0]    oe
);
    import pla_pkg::*;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout == '0 && oe == '0));

    assert_full_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == ST_SHIFT && cfg_load && ld_count == CNT_W'(CFG_BITS - 1))
        |=> (ld_state == ST_FULL));

    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == ST_SHIFT) |-> (ld_count != '0 && ld_count < CNT_W'(CFG_BITS)));

    assert_map_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state != ST_FULL) |=> $stable(cfg_q));

    assert_commit_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_commit && cfg_load) |=> $stable(cfg_q));
endmodule

bind pla_array pla_array_chk #(
    .CFG_BITS(CFG_BITS), .N_PIN(N_PIN), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_commit(cfg_commit),
    .ld_state  (ld_state),
    .ld_count  (ld_count),
    .cfg_q     (cfg_q),
    .dout      (dout),
    .oe        (oe)
);

// File: tb/test_pla_array.sv
module test_pla_array;
    localparam int CLK_PERIOD = 10;
    localparam int CW     = 1842;
    localparam int OR_BASE  = 1512;
    localparam int POL_BASE = 1832;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0, cfg_bit = 1'b0, cfg_commit = 1'b0;
    logic [7:0] ded_in = '0;
    logic [9:0] pad_in = '0;
    logic [9:0] dout, oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pla_array i_pla_array (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
        .cfg_commit(cfg_commit), .ded_in(ded_in), .pad_in(pad_in),
        .dout(dout), .oe(oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // {ded_in, pad_in, expected dout, expected oe} for map A
    localparam logic [37:0] VEC [7] = '{
        {8'h00, 10'h000, 10'h002, 10'h002},
        {8'h01, 10'h000, 10'h003, 10'h002},
        {8'h03, 10'h000, 10'h002, 10'h002},
        {8'h0C, 10'h000, 10'h000, 10'h002},
        {8'h80, 10'h001, 10'h003, 10'h003},
        {8'h8D, 10'h000, 10'h001, 10'h003},
        {8'hFF, 10'h3FF, 10'h001, 10'h003}
    };

    task automatic chk(input string req, input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [19:0] ref_eval(input logic [CW-1:0] c,
                                             input logic [7:0] d, input logic [9:0] p);
        logic [17:0] x;
        logic [41:0] term;
        logic [9:0]  rd, ro;
        x = {p, d};
        for (int t = 0; t < 42; t++) begin
            term[t] = 1'b1;
            for (int i = 0; i < 18; i++) begin
                if (c[t*36 + 2*i] && !x[i]) term[t] = 1'b0;
                if (c[t*36 + 2*i + 1] && x[i]) term[t] = 1'b0;
            end
        end
        for (int o = 0; o < 10; o++) begin
            logic s;
            s = 1'b0;
            for (int t = 0; t < 32; t++)
                if (c[OR_BASE + o*32 + t] && term[t]) s = 1'b1;
            rd[o] = c[POL_BASE + o] ? s : !s;
            ro[o] = term[32 + o];
        end
        return {rd, ro};
    endfunction

    function automatic logic [CW-1:0] map_a();
        logic [CW-1:0] c;
        c = '0;
        for (int t = 0; t < 42; t++) begin
            c[t*36] = 1'b1;
            c[t*36 + 1] = 1'b1;
        end
        c[0*36 +: 36] = '0; c[0*36 + 0] = 1'b1; c[0*36 + 3] = 1'b1;      // d0 & ~d1
        c[1*36 +: 36] = '0; c[1*36 + 16] = 1'b1;                         // pad0
        c[2*36 +: 36] = '0; c[2*36 + 4] = 1'b1; c[2*36 + 6] = 1'b1;      // d2 & d3
        c[3*36 +: 36] = '0; c[3*36 + 8] = 1'b1; c[3*36 + 9] = 1'b1;      // d4 & ~d4
        c[32*36 +: 36] = '0; c[32*36 + 14] = 1'b1;                       // oe0 = d7
        c[33*36 +: 36] = '0;                                             // oe1 = 1
        c[OR_BASE + 0] = 1'b1; c[OR_BASE + 1] = 1'b1;
        c[OR_BASE + 32 + 2] = 1'b1;
        c[OR_BASE + 64 + 3] = 1'b1;
        for (int o = 0; o < 10; o++) c[POL_BASE + o] = (o != 1);
        return c;
    endfunction

    function automatic logic [CW-1:0] map_rand();
        logic [CW-1:0] c;
        c = '0;
        for (int t = 0; t < 42; t++)
            for (int i = 0; i < 18; i++) begin
                int r;
                r = $urandom_range(0, 15);
                c[t*36 + 2*i]     = (r == 13 || r == 15);
                c[t*36 + 2*i + 1] = (r == 14 || r == 15);
            end
        for (int k = OR_BASE; k < CW; k++) c[k] = $urandom_range(0, 1) == 1;
        return c;
    endfunction

    task automatic shift_bits(input logic [CW-1:0] c, input int first, input int n);
        for (int k = first; k < first + n; k++) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_bit  = c[k];
        end
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    task automatic apply_in(input logic [7:0] d, input logic [9:0] p);
        ded_in = d;
        pad_in = p;
        #1;
    endtask

    task automatic chk_ref(input string req, input logic [CW-1:0] c);
        logic [19:0] e;
        e = ref_eval(c, ded_in, pad_in);
        chk(req, dout, e[19:10]);
        chk(req, oe, e[9:0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL watchdog got %0d expected below %0d cycles", cycles, WATCHDOG);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [CW-1:0] ma, mb;
        ma = map_a();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: default map keeps everything off
        apply_in(8'h00, 10'h000); chk("R1 dout", dout, '0); chk("R1 oe", oe, '0);
        apply_in(8'hFF, 10'h3FF); chk("R1 dout", dout, '0); chk("R1 oe", oe, '0);
        apply_in(8'hA5, 10'h15A); chk("R1 dout", dout, '0); chk("R1 oe", oe, '0);

        // R8, R9: shift map A; outputs stay default until commit
        shift_bits(ma, 0, 900);
        apply_in(8'h01, 10'h000); chk("R9 mid-load dout", dout, '0); chk("R9 mid-load oe", oe, '0);
        shift_bits(ma, 900, CW - 900);
        apply_in(8'h01, 10'h000); chk("R9 loaded dout", dout, '0); chk("R9 loaded oe", oe, '0);
        commit();

        // R2..R7: table walk for map A
        foreach (VEC[n]) begin
            apply_in(VEC[n][37:30], VEC[n][29:20]);
            chk($sformatf("R2-table%0d dout", n), dout, VEC[n][19:10]);
            chk($sformatf("R6 table%0d oe", n), oe, VEC[n][9:0]);
        end

        // R3: both-polarity term OR-ed into output 2 never fires
        apply_in(8'h10, 10'h000); chk("R3 both literals", dout[2] ? 10'h1 : 10'h0, 10'h0);
        apply_in(8'hEF, 10'h000); chk("R3 both literals", dout[2] ? 10'h1 : 10'h0, 10'h0);

        // R7: pad feedback with oe0 low, dedicated inputs idle
        apply_in(8'h00, 10'h001); chk("R7 pad feedback", dout, 10'h003);

        // R10: commit on a partial map is ignored
        mb = '0;
        shift_bits(mb, 0, 100);
        commit();
        apply_in(8'h01, 10'h000); chk("R10 partial commit dout", dout, 10'h003);
        chk("R10 partial commit oe", oe, 10'h002);

        // R10: commit held with load high does not install
        @(negedge clk);
        cfg_load = 1'b1; cfg_commit = 1'b1; cfg_bit = 1'b0;
        @(negedge clk);
        cfg_load = 1'b0; cfg_commit = 1'b0;
        apply_in(8'h01, 10'h000); chk("R10 commit during load", dout, 10'h003);

        // R1: reset returns to default map
        do_reset();
        apply_in(8'h01, 10'h001); chk("R1 after reset dout", dout, '0); chk("R1 after reset oe", oe, '0);

        // R2..R8: random maps against reference model
        for (int m = 0; m < 8; m++) begin
            mb = map_rand();
            shift_bits(mb, 0, CW);
            commit();
            for (int v = 0; v < 12; v++) begin
                apply_in(8'($urandom), 10'($urandom));
                chk_ref("R4 R5 R8 random", mb);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule